// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block is the software-visible register file for a bank of general-purpose pins. A plain 32-bit bus writes and reads it: an address, a write strobe, write data and read data. Each pin owns two configuration words. The first word holds the driven level, direction, mode, trigger type and trigger polarity. The second word holds the input-sense disable and a two-bit weak-pull code. A read-only bitmap, fed from a static input, shows which pins software may claim. That bitmap is packed 32 pins per word at the bottom of the address space.

The stored fields drive the pad controls directly. A pin drives its output only when it is in GPIO mode and set as an output. The two trigger bits go out to a separate interrupt unit. The pad input passes through a synchronizer and shows up, read-only, inside the first configuration word. It reads as zero while sensing is off for that pin. Interrupt status and enable registers are not part of this block.

Top module: `gpio_cfg_bank`

## Requirements
- R1: The ownership words sit at byte addresses 0x00, 0x04 and 0x08. Bit k of word w returns own_map[32w+k]. Bits above pin 93 read 0. Writes to these words have no effect.
- R2: Configuration word 1 of pin n sits at 0x100 + 8n and word 2 at 0x104 + 8n, for n from 0 to 93. A write stores the defined fields, and a later read returns them.
- R3: Word 1 layout is: bit 31 output level, bit 4 trigger type (1 = level), bit 3 trigger invert, bit 2 direction (1 = input), bit 0 mode (1 = GPIO). Every other bit except 30 reads 0 and ignores writes.
- R4: Bit 30 of word 1 ignores writes. It returns the pad input after a two-stage synchronizer, and it reads 0 while that pin's sense-disable bit is 1.
- R5: Word 2 layout is: bit 2 input-sense disable, bits 1:0 weak-pull code. Both drive pad_sense_dis and pad_pull[2n+1:2n]. The other bits read 0.
- R6: pad_out[n] follows bit 31 of word 1. pad_oe[n] is 1 only when bit 0 = 1 and bit 2 = 0. pad_gpio_mode[n] follows bit 0.
- R7: irq_trig_level[n] and irq_trig_invert[n] follow bits 4 and 3 of word 1.
- R8: After reset, word 1 reads 0x0000_0004 (input, native mode, output low) and word 2 reads 0x0000_0004 (sensing disabled, no pull).
- R9: Reads of unmapped or misaligned addresses (bits 1:0 not zero) return 0. Writes to them change no register.
- R10: Read data is registered. It is valid in the cycle after the address is presented. A write and a read of the same word in one cycle return the old value, and the new value appears from the next read on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| own_map | input | 94 | Static ownership bitmap, 1 = software may claim |
| pad_in | input | 94 | Asynchronous pad input levels |
| pad_out | output | 94 | Driven output levels |
| pad_oe | output | 94 | Output enables |
| pad_gpio_mode | output | 94 | 1 = GPIO mode, 0 = native function |
| pad_pull | output | 188 | Weak-pull code, two bits per pin |
| pad_sense_dis | output | 94 | Input-sense disable per pin |
| irq_trig_level | output | 94 | Trigger type per pin, to the interrupt unit |
| irq_trig_invert | output | 94 | Trigger invert per pin, to the interrupt unit |

## Verification
Every one of the 94 pins is written with a field pattern taken from the bits of its own index, and the writes carry junk in all unused bits. This shows whether a pin is aliased to a neighbour, whether a field sits in the wrong bit, and whether a reserved bit leaks. The input pattern is then applied twice. The first time sense-disable varies per pin; the second time sensing is on everywhere and the input is inverted. A stuck or ungated bit 30 shows up only in one of the two passes. The bench also reads the address holes and misaligned addresses, writes to read-only and unmapped space, and makes a write and read of the same word in one cycle. These steps isolate decoder boundary errors and read-timing errors.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    // Bit positions in configuration word 1
    localparam int W1_OUT  = 31;
    localparam int W1_IN   = 30;
    localparam int W1_TLVL = 4;
    localparam int W1_TINV = 3;
    localparam int W1_DIR  = 2;
    localparam int W1_MODE = 0;

    // Bit positions in configuration word 2
    localparam int W2_SDIS = 2;
    localparam int W2_PULL = 0;

    // Byte base of the per-pin word pairs
    localparam int CFG_BASE = 'h100;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       trig_inv;
        logic       dir_in;
        logic       gpio_mode;
        logic       sense_dis;
        logic [1:0] pull;
    } pin_cfg_t;

    localparam pin_cfg_t PIN_CFG_RST = '{
        out_lvl:   1'b0,
        trig_lvl:  1'b0,
        trig_inv:  1'b0,
        dir_in:    1'b1,
        gpio_mode: 1'b0,
        sense_dis: 1'b1,
        pull:      2'b00
    };

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS  = 94,
    parameter int ADDR_W    = 12,
    parameter int OWN_WORDS = 3,
    parameter int PIN_W     = 7,
    parameter int OWN_IDX_W = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 own_hit,
    output logic [OWN_IDX_W-1:0] own_idx,
    output logic                 cfg_hit,
    output logic [PIN_W-1:0]     cfg_pin,
    output logic                 cfg_sel2
);

    localparam logic [ADDR_W-1:0] BASE      = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-4:0] PIN_LIMIT = (ADDR_W-3)'(NUM_PINS);
    localparam logic [ADDR_W-3:0] OWN_LIMIT = (ADDR_W-2)'(OWN_WORDS);

    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-3:0] word_addr;
    logic              aligned;

    always_comb begin
        offs      = addr - BASE;
        word_addr = addr[ADDR_W-1:2];
        aligned   = (offs[1:0] == 2'b00);
        // Bitmapped group: one word per 32 pins from address zero
        own_hit   = aligned && (word_addr < OWN_LIMIT);
        own_idx   = word_addr[OWN_IDX_W-1:0];
        // Per-pin pairs: eight bytes per pin from the base
        cfg_hit   = aligned && (addr >= BASE) && (offs[ADDR_W-1:3] < PIN_LIMIT);
        cfg_pin   = offs[PIN_W+2:3];
        cfg_sel2  = offs[2];
    end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_w1,
    input  logic        wr_w2,
    input  logic [31:0] wdata,
    input  logic        pad_in,
    output pin_cfg_t    cfg,
    output logic [31:0] rd_w1,
    output logic [31:0] rd_w2
);

    typedef struct packed {
        pin_cfg_t               cfg;
        logic [SYNC_STAGES-1:0] sync;
    } slice_st_t;

    localparam slice_st_t SLICE_RST = '{cfg: PIN_CFG_RST, sync: '0};

    slice_st_t st_d, st_q;

    logic unused_wbits;
    assign unused_wbits = ^wdata[29:5];

    always_comb begin
        st_d      = st_q;
        // Newest sample enters at bit 0, oldest is the MSB
        st_d.sync = (st_q.sync << 1) | SYNC_STAGES'(pad_in);
        if (wr_w1) begin
            st_d.cfg.out_lvl   = wdata[W1_OUT];
            st_d.cfg.trig_lvl  = wdata[W1_TLVL];
            st_d.cfg.trig_inv  = wdata[W1_TINV];
            st_d.cfg.dir_in    = wdata[W1_DIR];
            st_d.cfg.gpio_mode = wdata[W1_MODE];
        end
        if (wr_w2) begin
            st_d.cfg.sense_dis = wdata[W2_SDIS];
            st_d.cfg.pull      = wdata[W2_PULL+1:W2_PULL];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLICE_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_w1          = '0;
        rd_w1[W1_OUT]  = st_q.cfg.out_lvl;
        rd_w1[W1_IN]   = st_q.sync[SYNC_STAGES-1] & ~st_q.cfg.sense_dis;
        rd_w1[W1_TLVL] = st_q.cfg.trig_lvl;
        rd_w1[W1_TINV] = st_q.cfg.trig_inv;
        rd_w1[W1_DIR]  = st_q.cfg.dir_in;
        rd_w1[W1_MODE] = st_q.cfg.gpio_mode;
        rd_w2          = '0;
        rd_w2[W2_SDIS] = st_q.cfg.sense_dis;
        rd_w2[W2_PULL+1:W2_PULL] = st_q.cfg.pull;
    end

    assign cfg = st_q.cfg;

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS    = 94,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   own_map,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_gpio_mode,
    output logic [2*NUM_PINS-1:0] pad_pull,
    output logic [NUM_PINS-1:0]   pad_sense_dis,
    output logic [NUM_PINS-1:0]   irq_trig_level,
    output logic [NUM_PINS-1:0]   irq_trig_invert
);

    localparam int OWN_WORDS = (NUM_PINS + 31) / 32;
    localparam int OWN_IDX_W = (OWN_WORDS > 1) ? $clog2(OWN_WORDS) : 1;
    localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    typedef struct packed {
        logic [31:0] rdata;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic                 own_hit;
    logic [OWN_IDX_W-1:0] own_idx;
    logic                 cfg_hit;
    logic [PIN_W-1:0]     cfg_pin;
    logic                 cfg_sel2;

    logic [31:0] rd_w1 [NUM_PINS];
    logic [31:0] rd_w2 [NUM_PINS];
    logic [OWN_WORDS*32-1:0] own_pad;

    gpio_addr_dec #(
        .NUM_PINS  (NUM_PINS),
        .ADDR_W    (ADDR_W),
        .OWN_WORDS (OWN_WORDS),
        .PIN_W     (PIN_W),
        .OWN_IDX_W (OWN_IDX_W)
    ) i_dec (
        .addr     (bus_addr),
        .own_hit  (own_hit),
        .own_idx  (own_idx),
        .cfg_hit  (cfg_hit),
        .cfg_pin  (cfg_pin),
        .cfg_sel2 (cfg_sel2)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pin_cfg_t cfg;
        logic     wr_w1;
        logic     wr_w2;
        logic     pin_sel;

        assign pin_sel = cfg_hit && (cfg_pin == PIN_W'(g));
        assign wr_w1   = bus_wr && pin_sel && !cfg_sel2;
        assign wr_w2   = bus_wr && pin_sel && cfg_sel2;

        gpio_pin_slice #(
            .SYNC_STAGES (SYNC_STAGES)
        ) i_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_w1  (wr_w1),
            .wr_w2  (wr_w2),
            .wdata  (bus_wdata),
            .pad_in (pad_in[g]),
            .cfg    (cfg),
            .rd_w1  (rd_w1[g]),
            .rd_w2  (rd_w2[g])
        );

        assign pad_out[g]           = cfg.out_lvl;
        assign pad_oe[g]            = cfg.gpio_mode & ~cfg.dir_in;
        assign pad_gpio_mode[g]     = cfg.gpio_mode;
        assign pad_pull[2*g +: 2]   = cfg.pull;
        assign pad_sense_dis[g]     = cfg.sense_dis;
        assign irq_trig_level[g]    = cfg.trig_lvl;
        assign irq_trig_invert[g]   = cfg.trig_inv;
    end

    always_comb begin
        own_pad                 = '0;
        own_pad[NUM_PINS-1:0]   = own_map;
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (own_hit) begin
            st_d.rdata = own_pad[{own_idx, 5'b00000} +: 32];
        end else if (cfg_hit) begin
            st_d.rdata = cfg_sel2 ? rd_w2[cfg_pin] : rd_w1[cfg_pin];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/gpio_cfg_bank_chk.sv
module gpio_cfg_bank_chk #(
    parameter int NUM_PINS = 94,
    parameter int ADDR_W   = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic [NUM_PINS-1:0]   own_map,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_gpio_mode,
    input logic [2*NUM_PINS-1:0] pad_pull,
    input logic [NUM_PINS-1:0]   pad_sense_dis,
    input logic [NUM_PINS-1:0]   irq_trig_level,
    input logic [NUM_PINS-1:0]   irq_trig_invert
);

    localparam int OWN_WORDS = (NUM_PINS + 31) / 32;
    localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic             c_cfg, c_own, c_sel2;
    logic [PIN_W-1:0] c_pin;
    logic [31:0]      c_own_word;

    always_comb begin
        int a;
        a      = int'(bus_addr);
        c_sel2 = bus_addr[2];
        c_cfg  = (bus_addr[1:0] == 2'b00) && (a >= 256) && (((a - 256) >> 3) < NUM_PINS);
        c_pin  = PIN_W'((a - 256) >> 3);
        c_own  = (bus_addr[1:0] == 2'b00) && ((a >> 2) < OWN_WORDS);
        for (int k = 0; k < 32; k++) begin
            int idx;
            idx = (a >> 2) * 32 + k;
            c_own_word[k] = (idx < NUM_PINS) ? own_map[idx] : 1'b0;
        end
    end

    logic             w1_q, w2_q, unm_q, own_q, sd_q;
    logic [PIN_W-1:0] pin_q;
    logic [31:0]      own_exp_q;
    logic             d_out, d_tl, d_ti, d_dir, d_mode, d_sdis;
    logic [1:0]       d_pull;

    logic unused_chk_bits;
    assign unused_chk_bits = ^bus_wdata[30:5];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w1_q  <= 1'b0;
            w2_q  <= 1'b0;
            unm_q <= 1'b0;
            own_q <= 1'b0;
            sd_q  <= 1'b0;
        end else begin
            w1_q  <= bus_wr && c_cfg && !c_sel2;
            w2_q  <= bus_wr && c_cfg && c_sel2;
            unm_q <= !c_cfg && !c_own;
            own_q <= c_own;
            sd_q  <= c_cfg && !c_sel2 && pad_sense_dis[c_pin];
        end
        pin_q     <= c_pin;
        own_exp_q <= c_own_word;
        d_out     <= bus_wdata[31];
        d_tl      <= bus_wdata[4];
        d_ti      <= bus_wdata[3];
        d_dir     <= bus_wdata[2];
        d_mode    <= bus_wdata[0];
        d_sdis    <= bus_wdata[2];
        d_pull    <= bus_wdata[1:0];
    end

    // R6
    out_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w1_q |-> (pad_out[pin_q] == d_out) && (pad_gpio_mode[pin_q] == d_mode));

    // R6
    out_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w1_q |-> (pad_oe[pin_q] == (d_mode && !d_dir)));

    // R7
    trig_export_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w1_q |-> (irq_trig_level[pin_q] == d_tl) && (irq_trig_invert[pin_q] == d_ti));

    // R5
    word2_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w2_q |-> (pad_sense_dis[pin_q] == d_sdis) && (pad_pull[2*pin_q +: 2] == d_pull));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unm_q |-> (bus_rdata == 32'h0));

    // R1
    own_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own_q |-> (bus_rdata == own_exp_q));

    // R4
    sense_off_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_q |-> (bus_rdata[30] == 1'b0));

endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) i_gpio_cfg_bank_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wr          (bus_wr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .own_map         (own_map),
    .pad_out         (pad_out),
    .pad_oe          (pad_oe),
    .pad_gpio_mode   (pad_gpio_mode),
    .pad_pull        (pad_pull),
    .pad_sense_dis   (pad_sense_dis),
    .irq_trig_level  (irq_trig_level),
    .irq_trig_invert (irq_trig_invert)
);

// File: tb/test_gpio_cfg_bank.sv
`timescale 1ns/1ps
module test_gpio_cfg_bank;

    localparam int NP = 94;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] own_map;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_out, pad_oe, pad_gpio_mode, pad_sense_dis;
    logic [NP-1:0] irq_trig_level, irq_trig_invert;
    logic [2*NP-1:0] pad_pull;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    gpio_cfg_bank i_gpio_cfg_bank (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_addr        (bus_addr),
        .bus_wr          (bus_wr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .own_map         (own_map),
        .pad_in          (pad_in),
        .pad_out         (pad_out),
        .pad_oe          (pad_oe),
        .pad_gpio_mode   (pad_gpio_mode),
        .pad_pull        (pad_pull),
        .pad_sense_dis   (pad_sense_dis),
        .irq_trig_level  (irq_trig_level),
        .irq_trig_invert (irq_trig_invert)
    );

    function automatic logic own_bit(int i);
        return ((i * 7 + 3) % 5) != 0;
    endfunction

    function automatic logic in_bit(int i);
        return ((i * 5) % 7) < 3;
    endfunction

    // Word 1 fields derived from the pin index (R3 layout)
    function automatic logic [31:0] w1_fields(int i);
        logic [31:0] r;
        r     = '0;
        r[31] = i[0];
        r[0]  = i[1];
        r[2]  = i[2];
        r[4]  = i[3];
        r[3]  = i[4];
        return r;
    endfunction

    function automatic logic dis_of(int i);
        return (i % 3) == 0;
    endfunction

    function automatic logic [11:0] a1(int i);
        return 12'(256 + 8 * i);
    endfunction

    function automatic logic [11:0] a2(int i);
        return 12'(260 + 8 * i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp;
        for (int i = 0; i < NP; i++) begin
            own_map[i] = own_bit(i);
            pad_in[i]  = in_bit(i);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state on the pad outputs
        for (int i = 0; i < NP; i++) begin
            chk("R8 pad_oe", 32'(pad_oe[i]), 32'h0);
            chk("R8 pad_out", 32'(pad_out[i]), 32'h0);
            chk("R8 pad_sense_dis", 32'(pad_sense_dis[i]), 32'h1);
            chk("R8 pad_gpio_mode", 32'(pad_gpio_mode[i]), 32'h0);
            chk("R8 pad_pull", 32'(pad_pull[2*i +: 2]), 32'h0);
        end
        // R8 R4 reset words: bit 30 stays 0 with sensing disabled
        for (int i = 0; i < NP; i++) begin
            rd(a1(i), d); chk("R8 R4 word1 reset", d, 32'h4);
            rd(a2(i), d); chk("R8 word2 reset", d, 32'h4);
        end

        // R1 ownership words and write immunity
        for (int w = 0; w < 3; w++) begin
            exp = '0;
            for (int k = 0; k < 32; k++)
                if (32 * w + k < NP) exp[k] = own_bit(32 * w + k);
            rd(12'(4 * w), d);
            chk("R1 own word", d, exp);
        end
        wr(12'h000, 32'h0);
        wr(12'h008, 32'hFFFF_FFFF);
        for (int w = 0; w < 3; w++) begin
            exp = '0;
            for (int k = 0; k < 32; k++)
                if (32 * w + k < NP) exp[k] = own_bit(32 * w + k);
            rd(12'(4 * w), d);
            chk("R1 own word after write", d, exp);
        end

        // R2 R3 R6 R7 word 1 sweep with junk in reserved bits
        for (int i = 0; i < NP; i++) begin
            wr(a1(i), w1_fields(i) | 32'h7FFF_FFE2);
            chk("R6 pad_out", 32'(pad_out[i]), 32'(w1_fields(i)[31]));
            chk("R6 pad_gpio_mode", 32'(pad_gpio_mode[i]), 32'(w1_fields(i)[0]));
            chk("R6 pad_oe", 32'(pad_oe[i]), 32'(w1_fields(i)[0] & ~w1_fields(i)[2]));
            chk("R7 irq_trig_level", 32'(irq_trig_level[i]), 32'(w1_fields(i)[4]));
            chk("R7 irq_trig_invert", 32'(irq_trig_invert[i]), 32'(w1_fields(i)[3]));
        end
        for (int i = 0; i < NP; i++) begin
            rd(a1(i), d);
            chk("R2 R3 word1 readback", d, w1_fields(i));
        end

        // R5 word 2 sweep
        for (int i = 0; i < NP; i++) begin
            wr(a2(i), 32'hFFFF_FFF8 | {29'h0, dis_of(i), 2'(i % 4)});
            chk("R5 pad_sense_dis", 32'(pad_sense_dis[i]), 32'(dis_of(i)));
            chk("R5 pad_pull", 32'(pad_pull[2*i +: 2]), 32'(i % 4));
        end
        for (int i = 0; i < NP; i++) begin
            rd(a2(i), d);
            chk("R5 word2 readback", d, {29'h0, dis_of(i), 2'(i % 4)});
        end

        // R4 input level gated per pin by sense disable
        repeat (4) @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            rd(a1(i), d);
            exp = w1_fields(i);
            exp[30] = in_bit(i) & ~dis_of(i);
            chk("R4 input level gated", d, exp);
        end

        // R4 sensing everywhere, inverted inputs
        for (int i = 0; i < NP; i++) wr(a2(i), 32'(i % 4));
        @(negedge clk);
        for (int i = 0; i < NP; i++) pad_in[i] = ~in_bit(i);
        repeat (4) @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            rd(a1(i), d);
            exp = w1_fields(i);
            exp[30] = ~in_bit(i);
            chk("R4 input level live", d, exp);
        end

        // R9 unmapped and misaligned reads
        rd(12'h00C, d); chk("R9 hole after own", d, 32'h0);
        rd(12'h080, d); chk("R9 hole 0x80", d, 32'h0);
        rd(12'h0FC, d); chk("R9 below base", d, 32'h0);
        rd(12'h3F0, d); chk("R9 past last pin", d, 32'h0);
        rd(12'h3F4, d); chk("R9 past last pin w2", d, 32'h0);
        rd(12'hFFC, d); chk("R9 top", d, 32'h0);
        rd(12'h101, d); chk("R9 misaligned", d, 32'h0);
        rd(12'h002, d); chk("R9 misaligned own", d, 32'h0);
        // R9 writes to unmapped space leave neighbours alone
        wr(12'h3F0, 32'hFFFF_FFFF);
        wr(12'h101, 32'hFFFF_FFFF);
        wr(12'h106, 32'hFFFF_FFFF);
        rd(a1(0), d);
        exp = w1_fields(0); exp[30] = ~in_bit(0);
        chk("R9 pin0 word1 untouched", d, exp);
        rd(a2(0), d);
        chk("R9 pin0 word2 untouched", d, 32'h0);
        rd(a1(NP - 1), d);
        exp = w1_fields(NP - 1); exp[30] = ~in_bit(NP - 1);
        chk("R9 last pin untouched", d, exp);

        // R10 write and read of the same word in one cycle
        @(negedge clk);
        bus_addr  = a1(5);
        bus_wr    = 1'b1;
        bus_wdata = 32'h8000_0015;
        @(negedge clk);
        bus_wr = 1'b0;
        exp = w1_fields(5); exp[30] = ~in_bit(5);
        chk("R10 old value on concurrent read", bus_rdata, exp);
        @(negedge clk);
        exp = 32'h8000_0015; exp[30] = ~in_bit(5);
        chk("R10 new value next read", bus_rdata, exp);
        chk("R6 pad_oe mode gpio dir input", 32'(pad_oe[5]), 32'h0);

        done = 1;
        summary();
        $finish;
    end

endmodule